// File: doc/BRIEF.md
# Divided Countdown Timer

This block is a one-shot countdown timer for a local interrupt controller. Software reaches it through three 32-bit registers that share a single select, write-strobe and read-data path: a divide configuration, an initial count and a current count. The divide configuration sets a power-of-two divisor on the base clock. A write of a non-zero initial count arms the timer, and the counter then steps down once per divided period. When the final period completes, the block raises a single-cycle expiry pulse and returns to idle.

Counting always follows a free-running prescaler, so a write that falls partway through a prescaler period has to wait for the next period boundary. A read of the current count reports the remaining time in whole divided periods, rounded up. This includes the partial period spent waiting for that first boundary.

Top module: `cdt_timer`

## Requirements
- R1: The divisor is 2 to the power e, where e = ({cfg[3], cfg[1], cfg[0]} + 1) mod 8. Code 0b111 gives divide-by-1, code 0b000 gives divide-by-2 and code 0b110 gives divide-by-128.
- R2: The select is 0 for divide configuration, 1 for initial count, 2 for current count and 3 for reserved. A divide-configuration write keeps only bits 3, 1 and 0, and every other bit reads back as zero. The reserved select always reads zero.
- R3: Writing a non-zero value N to the initial count arms the timer. The clock edge at which the count reaches zero comes K edges after the write edge, with N*div <= K <= N*div + div - 1. K equals N*div exactly when div is 1.
- R4: While the timer runs, a read of current count returns ceil(R/div), where R is the number of clock edges still to come before the count reaches zero. A read returns 0 when the timer is idle or has expired.
- R5: Writes to the current count register are ignored. The countdown and the other registers are unaffected.
- R6: A write to the initial count while the timer runs restarts it from the new value.
- R7: `expire_o` is high for exactly one cycle, the cycle after the edge at which the count reaches zero. The timer is then idle.
- R8: An initial count of zero leaves the timer idle and gives no expiry pulse. Writing zero to a running timer stops it.
- R9: Reset clears all three registers, leaves the timer idle and holds `expire_o` low.
- R10: The initial count register reads back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select for both read and write |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register, combinational |
| expire_o | output | 1 | Single-cycle expiry pulse |

## Verification
The assertions assume a write strobe lasts one cycle with a settled select. They also assume the divide code is not rewritten while a countdown is in progress, because the prescaler spacing check only holds while the mask is steady. The stimulus changes the configuration only while the timer is idle, and every input is driven at the falling edge.

The prescaler phase is not visible at the ports. The bench therefore measures the edges from each write to expiry and checks that count against the window in R3. It checks the first current-count read against the rounded-up remaining time measured afterwards.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   // Register select encoding (R2)
   typedef enum logic [1:0] {
      SEL_DIV  = 2'd0,
      SEL_INIT = 2'd1,
      SEL_CUR  = 2'd2,
      SEL_RSVD = 2'd3
   } cdt_sel_e;

   // Divide code holds {cfg[3], cfg[1], cfg[0]}
   localparam int unsigned EXP_W = 3;
   // Prescaler spans the largest divisor 2**(2**EXP_W - 1)
   localparam int unsigned PRE_W = (1 << EXP_W) - 1;
endpackage

// File: rtl/cdt_div_decode.sv
module cdt_div_decode
   import cdt_pkg::*;
#(
   parameter int unsigned CODE_W = EXP_W,
   parameter int unsigned MASK_W = PRE_W
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [MASK_W-1:0] mask_o
);
   if (MASK_W != (1 << CODE_W) - 1) begin : g_bad_width
      $error("cdt_div_decode: MASK_W must be 2**CODE_W - 1");
   end

   logic [CODE_W-1:0] expo;
   logic [MASK_W:0]   div_oh;

   always_comb begin
      // Exponent wraps modulo 2**CODE_W (R1)
      expo   = code_i + CODE_W'(1);
      div_oh = (MASK_W+1)'(1) << expo;
      mask_o = div_oh[MASK_W-1:0] - MASK_W'(1);
   end
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
   parameter int unsigned MASK_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MASK_W-1:0] mask_i,
   output logic              tick_o
);
   logic [MASK_W-1:0] pre_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + MASK_W'(1);
   end

   // Boundary when all low bits selected by the mask are ones
   assign tick_o = &(pre_q | ~mask_i);

   // R1
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && mask_i != '0) |=> (!tick_o || mask_i != $past(mask_i)));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
   parameter int unsigned DATA_W   = 32,
   parameter bit          SAT_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_val_i,
   output logic [DATA_W-1:0] remain_o,
   output logic              expire_o
);
   logic [DATA_W-1:0] cnt_q;
   logic              wait_q;
   logic              exp_q;
   logic [DATA_W:0]   sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wait_q <= 1'b0;
         exp_q  <= 1'b0;
      end else begin
         exp_q <= 1'b0;
         if (load_i) begin
            cnt_q  <= load_val_i;
            // Off-boundary load waits one partial period
            wait_q <= !tick_i && (load_val_i != '0);
         end else if (tick_i && cnt_q != '0) begin
            if (wait_q) begin
               wait_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q - DATA_W'(1);
               if (cnt_q == DATA_W'(1)) exp_q <= 1'b1;
            end
         end
      end
   end

   assign sum      = {1'b0, cnt_q} + (DATA_W+1)'(wait_q);
   assign expire_o = exp_q;

   if (SAT_READ) begin : g_sat
      assign remain_o = sum[DATA_W] ? '1 : sum[DATA_W-1:0];
   end else begin : g_wrap
      assign remain_o = sum[DATA_W-1:0];
   end

   // R7
   expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q |=> !exp_q);
   // R3
   expire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q |-> ($past(cnt_q) == DATA_W'(1) && $past(tick_i) && !$past(load_i)));
   // R8
   zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && load_val_i == '0) |=> (cnt_q == '0 && !exp_q));
   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=>
         (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - DATA_W'(1)));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
   import cdt_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter bit          SAT_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              expire_o
);
   if (DATA_W < 4) begin : g_bad_data_w
      $error("cdt_timer: DATA_W must hold the divide code bits");
   end

   logic [EXP_W-1:0]  code_q;
   logic [DATA_W-1:0] init_q;
   logic [PRE_W-1:0]  mask;
   logic              tick;
   logic              load;
   logic [DATA_W-1:0] remain;
   cdt_sel_e          sel;

   assign sel  = cdt_sel_e'(reg_sel);
   assign load = wr_en && (sel == SEL_INIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         init_q <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_DIV:  code_q <= {wr_data[3], wr_data[1:0]};
            SEL_INIT: init_q <= wr_data;
            default:  ;
         endcase
      end
   end

   cdt_div_decode #(.CODE_W(EXP_W), .MASK_W(PRE_W)) u_dec (
      .code_i (code_q),
      .mask_o (mask)
   );

   cdt_prescaler #(.MASK_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .mask_i (mask),
      .tick_o (tick)
   );

   cdt_counter #(.DATA_W(DATA_W), .SAT_READ(SAT_READ)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .load_i     (load),
      .load_val_i (wr_data),
      .remain_o   (remain),
      .expire_o   (expire_o)
   );

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_DIV: begin
            rd_data[3]   = code_q[2];
            rd_data[1:0] = code_q[1:0];
         end
         SEL_INIT: rd_data = init_q;
         SEL_CUR:  rd_data = remain;
         default:  rd_data = '0;
      endcase
   end

   // R5
   cur_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_CUR) |=> ($stable(code_q) && $stable(init_q)));
endmodule

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;
   localparam logic [31:0] V_CFG [NV] = '{32'h0000000F, 32'hFFFFFFF0, 32'h00000001,
      32'h00000006, 32'h00000003, 32'h00000008, 32'h00000009, 32'h0000007A};
   localparam logic [31:0] V_RB  [NV] = '{32'hB, 32'h0, 32'h1, 32'h2, 32'h3, 32'h8, 32'h9, 32'hA};
   localparam int          V_DIV [NV] = '{1, 2, 4, 8, 16, 32, 64, 128};
   localparam int          V_N   [NV] = '{5, 3, 2, 2, 1, 1, 1, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        expire_o;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   cdt_timer dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .expire_o(expire_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input int act, input int lo, input int hi);
      n_tests++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   // Returns at the falling edge in the cycle after the write edge
   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      reg_sel = s; wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [31:0] v);
      reg_sel = s;
      #1;
      v = rd_data;
   endtask

   // Counts edges from the current cycle until expire_o is seen
   task automatic wait_expire(output int k);
      int i = 0;
      while (!expire_o && i < 5000) begin
         @(negedge clk);
         i++;
      end
      k = i;
   endtask

   task automatic quiet(input int cycles, input string req);
      int hits = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (expire_o) hits++;
      end
      check(req, hits, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!done) $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int k;
      int r0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      rd(2'd0, v); check("R9 div cfg after reset", v, 0);
      rd(2'd1, v); check("R9 init after reset", v, 0);
      rd(2'd2, v); check("R9 cur after reset", v, 0);
      check("R9 expire after reset", expire_o, 0);
      rd(2'd3, v); check("R2 reserved read", v, 0);

      // Vector table: divide code, readback mask, countdown window
      for (int t = 0; t < NV; t++) begin
         wr(2'd0, V_CFG[t]);
         rd(2'd0, v); check("R2 cfg readback", v, V_RB[t]);
         wr(2'd1, 32'(V_N[t]));
         rd(2'd2, v); r0 = int'(v);
         wait_expire(k);
         // R1 R3 edge count from write to zero
         check_rng("R1/R3 expiry window", k, V_N[t]*V_DIV[t], V_N[t]*V_DIV[t] + V_DIV[t] - 1);
         // R4 rounded-up remaining periods
         check("R4 current count", r0, (k + V_DIV[t] - 1) / V_DIV[t]);
         @(negedge clk);
         check("R7 pulse one cycle", expire_o, 0);
         rd(2'd2, v); check("R7 idle after expiry", v, 0);
      end

      // Divide-by-1 from here on
      wr(2'd0, 32'h0000000B);

      // R6 restart
      wr(2'd1, 32'd10);
      @(negedge clk); @(negedge clk);
      check("R6 no early pulse", expire_o, 0);
      wr(2'd1, 32'd4);
      rd(2'd2, v); check("R6 reload count", v, 4);
      wait_expire(k);
      check("R6 restart length", k, 4);

      // R5 current-count write ignored
      wr(2'd1, 32'd20);
      wr(2'd2, 32'h5);
      rd(2'd2, v); check("R5 countdown continues", v, 18);
      rd(2'd1, v); check("R5 R10 init unchanged", v, 20);
      rd(2'd0, v); check("R5 cfg unchanged", v, 32'hB);

      // R8 zero stops a running timer
      wr(2'd1, 32'd0);
      rd(2'd2, v); check("R8 stop reads zero", v, 0);
      quiet(30, "R8 no pulse after stop");

      // R8 zero from idle
      wr(2'd1, 32'd0);
      quiet(20, "R8 zero idle no pulse");
      wr(2'd2, 32'h77);
      rd(2'd2, v); check("R5 cur write when idle", v, 0);

      // R10 full-width value
      wr(2'd1, 32'hFFFFFFFF);
      rd(2'd1, v); check("R10 init readback", v, 32'hFFFFFFFF);
      rd(2'd2, v); check("R4 full-width count", v, 32'hFFFFFFFF);
      wr(2'd1, 32'd0);

      // R9 reset in mid-run
      wr(2'd1, 32'd50);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      rd(2'd2, v); check("R9 cur cleared", v, 0);
      rd(2'd1, v); check("R9 init cleared", v, 0);
      rd(2'd0, v); check("R9 cfg cleared", v, 0);
      quiet(120, "R9 idle after reset");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule